// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block lives inside a behavioural model of a parallel NOR flash device. It watches the device's bus strobes and address and data lines. It turns recognised multi-cycle command sequences into single-cycle requests for the array engine that sits behind it. The requests cover word program, write-buffer start, buffer word, buffer commit, chip erase, sector erase and reset. A level output tells the read path to return identification data in place of array contents.

A write is taken when chip enable and write enable are both low and output enable is high. The write is counted once, on the first clock where that holds, however long the strobe stays active. Three modes are kept. The normal mode needs an unlock pair before every command. The bypass mode programs a word with just two writes. The identification mode redirects reads. An accelerate input forces bypass behaviour for as long as it is high, and while it is high sector protection does not block programming.

Each request is a one-cycle pulse in the clock after the write that completes it. The address and data of that write sit on a shared bus during the pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is counted only on the first clock of a run where ce_n=0, we_n=0 and oe_n=1. A strobe held for several clocks counts once. A cycle with oe_n=0 has no effect on the sequence.
- R2: In normal mode the sequence 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0 followed by a write of addr/data gives op_pgm=1 in the next cycle, with op_addr and op_data equal to that last write. Command addresses compare the low 12 address bits, and command codes compare the low 8 data bits.
- R3: A write that does not fit the sequence in progress returns the block to read mode. A write of 0xF0 outside a program, buffer or bypass state also returns it to read mode and pulses op_reset.
- R4: After the unlock pair, 0x555/0x20 enters bypass mode. In bypass mode a write of 0xA0 followed by addr/data pulses op_pgm. A write of 0x90 followed by 0x00 leaves bypass mode. A write of 0x90 followed by any other value stays in bypass mode. A write of 0xF0 is ignored in bypass mode.
- R5: While acc=1 the block acts in bypass mode without any unlock writes. When acc falls, the block returns to normal read mode.
- R6: A program (single or buffer commit) whose sector, addr[15:12], has its sect_prot bit set is dropped, and op_err pulses instead. With acc=1 the program is issued and no error is raised.
- R7: After the unlock pair, a write of 0x25 at an address in sector S starts a buffer load. The next write in S with value n (0..15) pulses op_wbstart with op_count=n+1. Each of the following n+1 writes in S pulses op_wbword, with op_index counting up from 0. A final write of 0x29 in S pulses op_wbcommit.
- R8: A buffer count above 15, a buffer word outside sector S, or a final write other than 0x29 in S pulses op_err and returns the block to read mode without op_wbstart or op_wbcommit.
- R9: The six writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, 0x555/0x10 pulse op_erase with op_chip=1.
- R10: If the sixth erase write is 0x30 at any address, it pulses op_erase with op_chip=0 and op_addr equal to that address. Each write of 0x30 that follows at once adds another sector erase. Any other write ends the run.
- R11: After the unlock pair, 0x555/0x90 sets rd_id=1. rd_id stays 1 through other writes until a write of 0xF0 clears it.
- R12: After reset every request output is 0, rd_id is 0 and the block is in normal read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| acc | input | 1 | Accelerate: forces bypass mode and overrides protection |
| sect_prot | input | 2^(ADDR_W-SECT_LSB) | Per-sector protection bits |
| op_pgm | output | 1 | Single-word program request |
| op_wbstart | output | 1 | Buffer load started |
| op_wbword | output | 1 | Buffer word written |
| op_wbcommit | output | 1 | Buffer program commit |
| op_erase | output | 1 | Erase request |
| op_chip | output | 1 | With op_erase: whole device |
| op_reset | output | 1 | Reset command seen |
| op_err | output | 1 | Dropped or aborted command |
| op_addr | output | ADDR_W | Address of the write that made the request |
| op_data | output | DATA_W | Data of the write that made the request |
| op_count | output | $clog2(WB_MAX)+1 | Buffer word count, valid with op_wbstart |
| op_index | output | $clog2(WB_MAX) | Buffer word index, valid with op_wbword |
| rd_id | output | 1 | Reads come from the identification register |

## Verification
The hardest case to reach is a program into a protected sector while the accelerate input overrides protection. The bench has to hold acc, then wait the cycle the block needs to fall into bypass, and only then issue the two-write program. It must also release acc and show that unlocked-only behaviour returns. The random phase gets there by choosing, on each pass, a fresh protection mask, a random target sector and whether acc is raised. It predicts a program or an error from the mask bit and acc. Directed runs cover held strobes, buffer aborts and the bypass exit pair.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 12,
  parameter int WB_MAX   = 16,
  parameter int CMD_AW   = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ce_n,
  input  logic                          we_n,
  input  logic                          oe_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             din,
  input  logic                          acc,
  input  logic [(1<<(ADDR_W-SECT_LSB))-1:0] sect_prot,
  output logic                          op_pgm,
  output logic                          op_wbstart,
  output logic                          op_wbword,
  output logic                          op_wbcommit,
  output logic                          op_erase,
  output logic                          op_chip,
  output logic                          op_reset,
  output logic                          op_err,
  output logic [ADDR_W-1:0]             op_addr,
  output logic [DATA_W-1:0]             op_data,
  output logic [$clog2(WB_MAX):0]       op_count,
  output logic [$clog2(WB_MAX)-1:0]     op_index,
  output logic                          rd_id
);
  localparam int SW    = ADDR_W - SECT_LSB;
  localparam int CNT_W = $clog2(WB_MAX);

  typedef enum logic [3:0] {
    S_RD, S_U1, S_U2, S_PG, S_E1, S_E2, S_E3, S_SE,
    S_WC, S_WL, S_WF, S_AS, S_BY, S_BP, S_BX
  } st_t;

  st_t st, eff;
  logic wr_q, acc_q;
  logic [SW-1:0] wb_sect;
  logic [CNT_W-1:0] left, idx;

  wire wr_now = !ce_n && !we_n && oe_n;
  wire wr_go  = wr_now && !wr_q;
  wire [7:0] cd = din[7:0];
  wire at555 = addr[CMD_AW-1:0] == CMD_AW'(12'h555);
  wire at2aa = addr[CMD_AW-1:0] == CMD_AW'(12'h2AA);
  wire [SW-1:0] sect = addr[ADDR_W-1:SECT_LSB];
  wire locked = sect_prot[sect] && !acc;
  wire in_byp = (st == S_BY) || (st == S_BP) || (st == S_BX);

  always_comb eff = (acc && !in_byp) ? S_BY : st;

  wire f0_ok = eff inside {S_RD, S_U1, S_U2, S_E1, S_E2, S_E3, S_SE, S_WC, S_AS};

  assign rd_id = (st == S_AS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_RD;
      wr_q <= 1'b0;
      acc_q <= 1'b0;
      wb_sect <= '0;
      left <= '0;
      idx <= '0;
      op_pgm <= 1'b0;
      op_wbstart <= 1'b0;
      op_wbword <= 1'b0;
      op_wbcommit <= 1'b0;
      op_erase <= 1'b0;
      op_chip <= 1'b0;
      op_reset <= 1'b0;
      op_err <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
      op_count <= '0;
      op_index <= '0;
    end else begin
      wr_q <= wr_now;
      acc_q <= acc;
      op_pgm <= 1'b0;
      op_wbstart <= 1'b0;
      op_wbword <= 1'b0;
      op_wbcommit <= 1'b0;
      op_erase <= 1'b0;
      op_chip <= 1'b0;
      op_reset <= 1'b0;
      op_err <= 1'b0;
      if (acc && !in_byp) st <= S_BY;
      if (!acc && acc_q) begin
        st <= S_RD;
      end else if (wr_go) begin
        op_addr <= addr;
        op_data <= din;
        if (cd == 8'hF0 && f0_ok) begin
          st <= S_RD;
          op_reset <= 1'b1;
        end else begin
          case (eff)
            S_RD: if (at555 && cd == 8'hAA) st <= S_U1;
            S_U1: st <= (at2aa && cd == 8'h55) ? S_U2 : S_RD;
            S_U2: begin
              st <= S_RD;
              if (cd == 8'h25) begin
                st <= S_WC;
                wb_sect <= sect;
              end else if (at555) begin
                case (cd)
                  8'hA0: st <= S_PG;
                  8'h90: st <= S_AS;
                  8'h20: st <= S_BY;
                  8'h80: st <= S_E1;
                  default: st <= S_RD;
                endcase
              end
            end
            S_PG, S_BP: begin
              st <= (eff == S_BP) ? S_BY : S_RD;
              if (locked) op_err <= 1'b1;
              else op_pgm <= 1'b1;
            end
            S_E1: st <= (at555 && cd == 8'hAA) ? S_E2 : S_RD;
            S_E2: st <= (at2aa && cd == 8'h55) ? S_E3 : S_RD;
            S_E3: begin
              st <= S_RD;
              if (at555 && cd == 8'h10) begin
                op_erase <= 1'b1;
                op_chip <= 1'b1;
              end else if (cd == 8'h30) begin
                op_erase <= 1'b1;
                st <= S_SE;
              end
            end
            S_SE: begin
              if (cd == 8'h30) op_erase <= 1'b1;
              else st <= S_RD;
            end
            S_WC: begin
              if (din > DATA_W'(WB_MAX - 1) || sect != wb_sect) begin
                op_err <= 1'b1;
                st <= S_RD;
              end else begin
                op_wbstart <= 1'b1;
                op_count <= (CNT_W+1)'(din[CNT_W-1:0]) + (CNT_W+1)'(1);
                left <= din[CNT_W-1:0];
                idx <= '0;
                st <= S_WL;
              end
            end
            S_WL: begin
              if (sect != wb_sect) begin
                op_err <= 1'b1;
                st <= S_RD;
              end else begin
                op_wbword <= 1'b1;
                op_index <= idx;
                idx <= idx + CNT_W'(1);
                if (left == '0) st <= S_WF;
                else left <= left - CNT_W'(1);
              end
            end
            S_WF: begin
              st <= S_RD;
              if (cd == 8'h29 && sect == wb_sect && !locked) op_wbcommit <= 1'b1;
              else op_err <= 1'b1;
            end
            S_AS: st <= S_AS;
            S_BY: begin
              if (cd == 8'hA0) st <= S_BP;
              else if (cd == 8'h90) st <= S_BX;
              else st <= S_BY;
            end
            S_BX: st <= (cd == 8'h00) ? S_RD : S_BY;
            default: st <= S_RD;
          endcase
        end
      end
    end
  end

  a_r1_ops_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pgm || op_wbstart || op_wbword || op_wbcommit || op_erase || op_reset || op_err)
    |=> !(op_pgm || op_wbstart || op_wbword || op_wbcommit || op_erase || op_reset || op_err));

  a_r6_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> !(op_pgm || op_wbcommit || op_wbword || op_wbstart || op_erase));

  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    op_wbstart |-> (op_count >= 1 && op_count <= (CNT_W+1)'(WB_MAX)));

  a_r11_id_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_id) |-> $past(wr_go));

  a_r11_id_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_id) |-> $past(wr_go || acc));

  a_r9_chip_with_erase: assert property (@(posedge clk) disable iff (!rst_n)
    op_chip |-> op_erase);
endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, acc = 1'b0;
  logic [15:0] addr = '0, din = '0, sect_prot = '0;
  logic op_pgm, op_wbstart, op_wbword, op_wbcommit, op_erase, op_chip, op_reset, op_err, rd_id;
  logic [15:0] op_addr, op_data;
  logic [4:0] op_count;
  logic [3:0] op_index;
  int checks = 0, errors = 0;
  bit done = 0;
  logic s_pgm, s_wbs, s_wbw, s_cmt, s_er, s_chip, s_rst, s_err;
  logic [15:0] s_addr, s_data;
  logic [4:0] s_cnt;
  logic [3:0] s_idx;

  always #4 clk = ~clk;

  flash_cmd_decoder u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .acc(acc), .sect_prot(sect_prot),
    .op_pgm(op_pgm), .op_wbstart(op_wbstart), .op_wbword(op_wbword),
    .op_wbcommit(op_wbcommit), .op_erase(op_erase), .op_chip(op_chip),
    .op_reset(op_reset), .op_err(op_err), .op_addr(op_addr), .op_data(op_data),
    .op_count(op_count), .op_index(op_index), .rd_id(rd_id));

  function automatic bit exp_locked(input logic [15:0] a, input logic [15:0] m, input logic ac);
    return m[a[15:12]] && !ac;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic snap();
    s_pgm = op_pgm; s_wbs = op_wbstart; s_wbw = op_wbword; s_cmt = op_wbcommit;
    s_er = op_erase; s_chip = op_chip; s_rst = op_reset; s_err = op_err;
    s_addr = op_addr; s_data = op_data; s_cnt = op_count; s_idx = op_index;
  endtask

  task automatic wr_n(input logic [15:0] a, input logic [15:0] d, input int hold);
    @(negedge clk);
    ce_n = 0; we_n = 0; oe_n = 1; addr = a; din = d;
    repeat (hold) @(negedge clk);
    ce_n = 1; we_n = 1;
    snap();
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    wr_n(a, d, 1);
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle(3);
    rst_n = 1;
    idle(1);
    snap();
    chk("R12 reset ops", {s_pgm, s_wbs, s_wbw, s_cmt, s_er, s_rst, s_err}, 0);
    chk("R12 reset rd_id", rd_id, 0);

    // R2 normal four-write program
    unlock();
    wr(16'h0555, 16'h00A0);
    chk("R2 no early pgm", s_pgm, 0);
    wr(16'h1234, 16'hBEEF);
    chk("R2 pgm", s_pgm, 1);
    chk("R2 addr", s_addr, 16'h1234);
    chk("R2 data", s_data, 16'hBEEF);

    // R1 held strobe counts once, oe_n low cycle ignored
    wr_n(16'h0555, 16'h00AA, 3);
    wr(16'h02AA, 16'h0055);
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 0; addr = 16'h0777; din = 16'h0012;
    @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
    wr(16'h0555, 16'h00A0);
    wr(16'h0042, 16'h1111);
    chk("R1 held and oe-low ignored", s_pgm, 1);

    // R3 broken sequence, then F0
    unlock();
    wr(16'h0555, 16'h0077);
    wr(16'h0555, 16'h00A0);
    wr(16'h0100, 16'h2222);
    chk("R3 broken no pgm", s_pgm, 0);
    unlock();
    wr(16'h0000, 16'h00F0);
    chk("R3 reset pulse", s_rst, 1);
    wr(16'h0555, 16'h00A0);
    wr(16'h0100, 16'h3333);
    chk("R3 after F0 no pgm", s_pgm, 0);

    // R11 autoselect
    unlock();
    wr(16'h0555, 16'h0090);
    chk("R11 rd_id set", rd_id, 1);
    wr(16'h1000, 16'h1234);
    chk("R11 rd_id held", rd_id, 1);
    chk("R11 no op", {s_pgm, s_er, s_err}, 0);
    wr(16'h0000, 16'h00F0);
    chk("R11 rd_id cleared", rd_id, 0);

    // R4 bypass
    unlock();
    wr(16'h0555, 16'h0020);
    wr(16'h0000, 16'h00A0);
    wr(16'h2345, 16'h55AA);
    chk("R4 bypass pgm", s_pgm, 1);
    chk("R4 bypass data", s_data, 16'h55AA);
    wr(16'h0000, 16'h00F0);
    chk("R4 F0 ignored", s_rst, 0);
    wr(16'h0000, 16'h0090);
    wr(16'h0000, 16'h0001);
    wr(16'h0000, 16'h00A0);
    wr(16'h3456, 16'h0101);
    chk("R4 90/01 stays bypass", s_pgm, 1);
    wr(16'h0000, 16'h0090);
    wr(16'h0000, 16'h0000);
    wr(16'h0000, 16'h00A0);
    wr(16'h3456, 16'h0202);
    chk("R4 exit to normal", s_pgm, 0);

    // R6 protection
    sect_prot = 16'h0004;
    unlock();
    wr(16'h0555, 16'h00A0);
    wr(16'h2100, 16'h0A0A);
    chk("R6 protected dropped", s_pgm, 0);
    chk("R6 protected err", s_err, 1);
    unlock();
    wr(16'h0555, 16'h00A0);
    wr(16'h3100, 16'h0B0B);
    chk("R6 unprotected pgm", s_pgm, 1);

    // R5 accelerate
    @(negedge clk); acc = 1;
    idle(2);
    wr(16'h0000, 16'h00A0);
    wr(16'h2100, 16'h0C0C);
    chk("R5 acc pgm", s_pgm, 1);
    chk("R5 acc no err", s_err, 0);
    @(negedge clk); acc = 0;
    idle(2);
    wr(16'h0000, 16'h00A0);
    wr(16'h3000, 16'h0001);
    chk("R5 release normal", s_pgm, 0);
    sect_prot = 16'h0000;

    // R7 write buffer
    unlock();
    wr(16'h5000, 16'h0025);
    wr(16'h5000, 16'h0003);
    chk("R7 start", s_wbs, 1);
    chk("R7 count", s_cnt, 4);
    for (int i = 0; i < 4; i++) begin
      wr(16'h5000 + 16'(i), 16'h0F00 + 16'(i));
      chk("R7 word", s_wbw, 1);
      chk("R7 index", s_idx, 4'(i));
    end
    wr(16'h5000, 16'h0029);
    chk("R7 commit", s_cmt, 1);

    // R8 aborts
    unlock();
    wr(16'h5000, 16'h0025);
    wr(16'h5000, 16'h0010);
    chk("R8 overflow err", s_err, 1);
    chk("R8 overflow no start", s_wbs, 0);
    unlock();
    wr(16'h5000, 16'h0025);
    wr(16'h5000, 16'h0001);
    wr(16'h6000, 16'h0001);
    chk("R8 wrong sector err", s_err, 1);
    unlock();
    wr(16'h5000, 16'h0025);
    wr(16'h5000, 16'h0000);
    wr(16'h5001, 16'h0001);
    wr(16'h5000, 16'h0028);
    chk("R8 bad confirm err", s_err, 1);
    chk("R8 bad confirm no commit", s_cmt, 0);

    // R9 chip erase
    unlock(); wr(16'h0555, 16'h0080); unlock();
    wr(16'h0555, 16'h0010);
    chk("R9 chip erase", {s_er, s_chip}, 2'b11);

    // R10 sector erase runs
    unlock(); wr(16'h0555, 16'h0080); unlock();
    wr(16'h7000, 16'h0030);
    chk("R10 sector erase", {s_er, s_chip}, 2'b10);
    chk("R10 sector addr", s_addr, 16'h7000);
    wr(16'h9000, 16'h0030);
    chk("R10 second sector", s_er, 1);
    wr(16'h0000, 16'h0011);
    wr(16'hA000, 16'h0030);
    chk("R10 run ended", s_er, 0);

    // R6/R5/R2 random programs
    for (int k = 0; k < 40; k++) begin
      logic [15:0] a, d, m;
      logic ac;
      a = 16'($urandom); d = 16'($urandom); m = 16'($urandom); ac = 1'($urandom);
      sect_prot = m;
      if (ac) begin
        @(negedge clk); acc = 1; idle(2);
        wr(16'h0000, 16'h00A0);
      end else begin
        unlock();
        wr(16'h0555, 16'h00A0);
      end
      wr(a, d);
      chk("R6 random pgm", s_pgm, !exp_locked(a, m, ac));
      chk("R6 random err", s_err, exp_locked(a, m, ac));
      if (s_pgm) chk("R2 random data", s_data, d);
      if (ac) begin
        @(negedge clk); acc = 0; idle(2);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule